// File: doc/BRIEF.md
# Edge-latched bridge interrupt aggregator

This block gathers a configurable number of edge-type event lines into a small register-mapped interrupt controller and drives one level interrupt line to an upstream controller. Every rising edge on a source line is recorded in a pending (cause) register, even when that source is disabled. A separate enable (mask) register decides which recorded events are forwarded. The upstream line is high while any pending bit is also enabled.

Software reaches three 32-bit words through a simple register port: a write strobe, a word address, write data, and read data that is combinational from the address. A pending bit is acknowledged by writing 0 to its position in the cause word. Positions written as 1 are left alone. A read-only status word gives the number of the highest pending enabled source. Because events latch while they are disabled, software should acknowledge a source before enabling it. Otherwise an old event fires as soon as the source is enabled.

Top module: `edge_irq_bridge`

## Requirements
- R1: After reset, the cause word (word address 0, byte offset 0x00), the mask word (word address 1, byte offset 0x04) and the status word (word address 2, byte offset 0x08) all read 0, and `irq_o` is 0.
- R2: A source input that is low in one cycle and high in the next sets its cause bit at that clock edge. This happens whatever the value of the matching mask bit. Bit i of the cause word corresponds to `src_i[i]`.
- R3: An input that stays high does not set its cause bit again after the bit has been cleared. A falling edge sets nothing.
- R4: A write to the cause word clears each implemented bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged.
- R5: If a rising edge and a clearing write hit the same cause bit in the same cycle, the bit ends at 1.
- R6: A write to the mask word stores the implemented bits, and a read returns them. Mask bit 1 enables forwarding of that source and 0 blocks it. The mask changes only on a mask-word write.
- R7: Bits at or above N_SRC read 0 in the cause and mask words and ignore writes. Word address 3 reads 0.
- R8: `irq_o` is a register that equals the OR over all bits of (cause AND mask) as it stood one cycle earlier. It therefore changes one clock after the cause or mask state changes.
- R9: The status word reads bit 31 = 1 when any bit of (cause AND mask) is set. In that case bits 4:0 hold the index of the highest such bit. All other status bits are 0, and all bits are 0 when nothing enabled is pending.
- R10: Reading any word does not change the cause or mask state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Source event lines, synchronous to clk_i |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address: 0 cause, 1 mask, 2 status |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered upstream interrupt line |

## Verification
The bench sets events on disabled sources and then enables them. The upstream line must rise from the old event: a design that gated capture with the mask would leave it low. It holds a source high across an acknowledge, and it lands an edge in the same cycle as a clearing write. A level-sensitive design would re-set the bit in the first case, and a clear-wins design would lose the event in the second. It writes ones above the implemented width, reads the status word with several pending bits to catch a lowest-first encoder, and times the upstream line to the exact clock. An output driven combinationally would show up one cycle early.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int WORD_W      = 32;
  localparam int REG_CAUSE   = 0;
  localparam int REG_MASK    = 1;
  localparam int REG_STAT    = 2;
  localparam int STAT_IDX_W  = 5;
  localparam int STAT_ANY_B  = 31;
  localparam int STAT_PAD_W  = STAT_ANY_B - STAT_IDX_W;
endpackage

// File: rtl/irqb_edge_det.sv
module irqb_edge_det #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/irqb_cause_bank.sv
module irqb_cause_bank #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] cause_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      // set has priority over a same-cycle clear
      else         bit_q <= (bit_q & (~wr_i | keep_i[b])) | set_i[b];
    end
    assign cause_o[b] = bit_q;
  end
endmodule

// File: rtl/irqb_prio_enc.sv
module irqb_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge
  import irqb_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]      edge_w;
  logic [N_SRC-1:0]      cause_q;
  logic [N_SRC-1:0]      mask_q;
  logic [N_SRC-1:0]      pend_w;
  logic                  stat_any;
  logic [STAT_IDX_W-1:0] stat_idx;
  logic                  irq_q;
  logic                  sel_cause, sel_mask, sel_stat;

  assign sel_cause = (addr_i == ADDR_W'(REG_CAUSE));
  assign sel_mask  = (addr_i == ADDR_W'(REG_MASK));
  assign sel_stat  = (addr_i == ADDR_W'(REG_STAT));

  irqb_edge_det #(.N(N_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (edge_w)
  );

  irqb_cause_bank #(.N(N_SRC)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (edge_w),
    .wr_i    (we_i & sel_cause),
    .keep_i  (wdata_i[N_SRC-1:0]),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mask_q <= '0;
    else if (we_i & sel_mask) mask_q <= wdata_i[N_SRC-1:0];
  end

  assign pend_w = cause_q & mask_q;

  irqb_prio_enc #(.N(N_SRC), .IDX_W(STAT_IDX_W)) u_prio (
    .pend_i (pend_w),
    .any_o  (stat_any),
    .idx_o  (stat_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= stat_any;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (sel_cause)     rdata_o = WORD_W'(cause_q);
    else if (sel_mask) rdata_o = WORD_W'(mask_q);
    else if (sel_stat) rdata_o = {stat_any & 1'b1, {STAT_PAD_W{1'b0}}, stat_any ? stat_idx : '0};
  end
endmodule

// File: rtl/edge_irq_bridge_chk.sv
module edge_irq_bridge_chk #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  edge_w,
  input logic [N_SRC-1:0]  cause_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic              irq_o,
  input logic              stat_any,
  input logic [4:0]        stat_idx
);
  localparam logic [N_SRC-1:0] ONE = {{(N_SRC-1){1'b0}}, 1'b1};

  // R2 / R5: an edge always lands in the cause word
  a_r2_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_w != '0) |=> ((cause_q & $past(edge_w)) == $past(edge_w)));

  // R3: no cause bit rises without an edge
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(edge_w)) == '0));

  // R6: mask moves only on a mask write
  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(1)) |=> $stable(mask_q));

  // R8: output follows pending state one cycle later
  a_r8_irq_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(cause_q & mask_q))));

  // R9: index names the highest pending enabled bit
  a_r9_stat_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_any |-> (((cause_q & mask_q) >> stat_idx) == ONE));
endmodule

bind edge_irq_bridge edge_irq_bridge_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .edge_w   (edge_w),
  .cause_q  (cause_q),
  .mask_q   (mask_q),
  .irq_o    (irq_o),
  .stat_any (stat_any),
  .stat_idx (stat_idx)
);

// File: tb/edge_irq_bridge_bench.sv
module edge_irq_bridge_bench;
  localparam int N = 20;

  typedef struct packed {
    logic [N-1:0] src;
    logic         we;
    logic [1:0]   wa;
    logic [31:0]  wd;
    logic [1:0]   ra;
    logic [31:0]  exp_rd;
    logic         exp_irq;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{20'h00001, 1'b0, 2'd0, 32'h0,        2'd0, 32'h00000001, 1'b0, 8'd2}, // R2 masked edge latches
    '{20'h00001, 1'b1, 2'd0, 32'hFFFFFFFE, 2'd0, 32'h00000000, 1'b0, 8'd3}, // R3 steady high after clear
    '{20'h00000, 1'b0, 2'd0, 32'h0,        2'd0, 32'h00000000, 1'b0, 8'd3}, // R3 falling edge
    '{20'h80021, 1'b0, 2'd0, 32'h0,        2'd0, 32'h00080021, 1'b0, 8'd2}, // R2 three edges
    '{20'h80021, 1'b1, 2'd1, 32'hFFFFFF20, 2'd1, 32'h000FFF20, 1'b1, 8'd7}, // R7 mask upper bits dropped
    '{20'h80021, 1'b0, 2'd0, 32'h0,        2'd2, 32'h80000013, 1'b1, 8'd9}, // R9 highest is 19
    '{20'h80021, 1'b1, 2'd0, 32'hFFF7FFFF, 2'd2, 32'h80000005, 1'b1, 8'd4}, // R4 ack bit 19
    '{20'h80021, 1'b1, 2'd0, 32'hFFFFFFDF, 2'd2, 32'h00000000, 1'b0, 8'd8}, // R8 nothing enabled pending
    '{20'h80021, 1'b1, 2'd1, 32'h00000001, 2'd0, 32'h00000001, 1'b1, 8'd6}, // R6 stale event exposed
    '{20'h00000, 1'b1, 2'd0, 32'hFFFFFFFF, 2'd0, 32'h00000001, 1'b1, 8'd4}, // R4 ones keep
    '{20'h00000, 1'b1, 2'd0, 32'h00000000, 2'd0, 32'h00000000, 1'b0, 8'd4}, // R4 zeros clear
    '{20'h00000, 1'b1, 2'd0, 32'hFFF00000, 2'd0, 32'h00000000, 1'b0, 8'd7}, // R7 cause upper bits
    '{20'h00000, 1'b0, 2'd0, 32'h0,        2'd3, 32'h00000000, 1'b0, 8'd7}  // R7 unmapped word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_irq_bridge #(.N_SRC(N), .ADDR_W(2)) u_edge_irq_bridge (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, "R1 cause", 32'h0);
    rd(2'd1, "R1 mask", 32'h0);
    rd(2'd2, "R1 status", 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src = TBL[i].src; we = TBL[i].we; addr = TBL[i].wa; wdata = TBL[i].wd;
      @(posedge clk);
      #1 we = 1'b0; addr = TBL[i].ra;
      @(posedge clk);
      #1;
      chk($sformatf("R%0d row%0d rdata", TBL[i].req, i), rdata, TBL[i].exp_rd);
      chk($sformatf("R%0d row%0d irq", TBL[i].req, i), {31'b0, irq}, {31'b0, TBL[i].exp_irq});
    end

    // R5 edge and clearing write in one cycle
    @(negedge clk);
    src = 20'h00008; we = 1'b1; addr = 2'd0; wdata = 32'h0;
    @(posedge clk);
    #1 we = 1'b0;
    rd(2'd0, "R5 set wins", 32'h00000008);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);

    // R10 repeated reads do not disturb state
    repeat (2) @(posedge clk);
    #1 rd(2'd0, "R10 cause reread", 32'h00000008);
    rd(2'd2, "R10 status read", 32'h0);
    rd(2'd0, "R10 cause after status", 32'h00000008);

    // R8 exact output latency
    @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 32'h0;
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 32'h0;
    @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 32'h8;
    @(negedge clk); we = 1'b0; src = '0;
    rd(2'd0, "R3 held high then cleared", 32'h0);
    @(negedge clk); src = 20'h00008;
    @(posedge clk);
    #1 chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    rd(2'd2, "R9 status bit3", 32'h80000003);
    @(posedge clk);
    #1 chk("R8 irq one cycle later", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule